// File: doc/BRIEF.md
# Hard-Decision Trellis Decoder for a Rate-1/2 Four-State Code

This block recovers the information bits of one frame that was protected by a rate-1/2 convolutional code with memory 2. The generators are 111 and 101. The decoder takes one 2-bit hard-decision symbol per accepted cycle. For every symbol it scores the four trellis states by Hamming distance and keeps the best incoming path for each state. It records one survivor decision bit per state in a per-frame memory. The encoder is assumed to have appended two zero tail bits, so the frame holds L information symbols plus 2 tail symbols.

When the last symbol of the frame arrives, the decoder walks the stored decisions backwards from state 0. It writes the recovered bits into a small buffer. It then streams the first L of them, oldest first, on consecutive cycles, and marks the final one. The two tail bits are never emitted.

A four-state controller sequences the work:
- IDLE waits for a symbol flagged as a frame start. An accepted start symbol moves it to RECV.
- RECV keeps accepting symbols. The closing symbol moves it to TRACE, or back to IDLE when the frame holds fewer than 3 symbols.
- TRACE spends one cycle per received symbol and then moves to EMIT.
- EMIT outputs L bits and then returns to IDLE.

Top module: `hd_viterbi_dec`

## Requirements
- R1: After reset, sym_ready is 1, and out_valid and out_last are 0.
- R2: The trellis state is {Q1,Q2}, with Q1 the newest past input. The next state is {u,Q1}. The symbol expected on a branch has sym_data[1] = u^Q1^Q2 and sym_data[0] = u^Q2. A frame received without errors decodes to exactly the encoded information bits. For example, the symbols 11,01,01,00,10,11 decode to 1,1,0,1.
- R3: The decoder is maximum-likelihood with zero-tail termination. Every metric starts infinite except state 0, and ties choose the predecessor with Q2=0. As a result, one flipped symbol bit in a frame, or two flips many symbols apart, still decode to the transmitted bits.
- R4: A frame of N symbols yields exactly N-2 output bits. They come in forward order on consecutive cycles with out_valid high. out_last is high only with the final bit, and sym_ready returns the cycle after it.
- R5: While the decoder is in IDLE, a valid symbol without sym_first is ignored. It produces no output and the decoder stays ready.
- R6: While sym_ready is low (during TRACE and EMIT), sym_valid and its flags are ignored. sym_ready falls on the cycle after the closing symbol is accepted.
- R7: A symbol with sym_first set, arriving in RECV, discards the partial frame and starts a new one with that symbol.
- R8: A frame closes on its MAX_SYMS-th symbol even when sym_last is not set, and decodes MAX_SYMS-2 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | A received symbol is present |
| sym_first | input | 1 | The symbol is the first of a frame |
| sym_last | input | 1 | The symbol closes the frame |
| sym_data | input | 2 | Hard-decision symbol; bit 1 is the first code bit |
| sym_ready | output | 1 | Symbols are accepted this cycle |
| out_valid | output | 1 | A decoded bit is present |
| out_bit | output | 1 | Decoded information bit |
| out_last | output | 1 | The decoded bit is the last of the frame |

## Verification
The decoder is exercised with several frames:
- The known 1101 frame without errors, which confirms the branch labelling and the state transitions.
- The same frame with one flipped bit, and a 40-bit frame with two distant flips, which separate true metric comparison from simple re-encoding.
- All-zero and all-one frames, which stress the saturated initial metrics and the tie-break.
- A frame closed only by reaching the length limit.

Start-less symbols in IDLE, symbols driven while busy, and a frame restarted mid-way show that only properly framed symbols reach the path metrics. Each of these cases shows up at the output as a wrong bit count or wrong bits.

// File: rtl/vit_pkg.sv
package vit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RECV  = 2'd1,
        ST_TRACE = 2'd2,
        ST_EMIT  = 2'd3
    } vit_state_e;

    // Code bits for input u leaving state prev = {Q1,Q2}
    function automatic logic [1:0] branch_sym(input logic u, input logic [1:0] prev);
        return {u ^ prev[1] ^ prev[0], u ^ prev[0]};
    endfunction

    function automatic logic [1:0] ham2(input logic [1:0] a, input logic [1:0] b);
        logic [1:0] d;
        d = a ^ b;
        return {1'b0, d[1]} + {1'b0, d[0]};
    endfunction

endpackage

// File: rtl/vit_acs.sv
module vit_acs
    import vit_pkg::*;
#(
    parameter int MW = 10
) (
    input  logic [1:0]           rx,
    input  logic [3:0][MW-1:0]   pm_in,
    output logic [3:0][MW-1:0]   pm_out,
    output logic [3:0]           dec
);

    function automatic logic [MW-1:0] sat_add(input logic [MW-1:0] a, input logic [1:0] b);
        logic [MW:0] s;
        s = {1'b0, a} + {{(MW-1){1'b0}}, b};
        return s[MW] ? {MW{1'b1}} : s[MW-1:0];
    endfunction

    // Target state t = {u, a}; predecessors are {a,0} and {a,1}
    for (genvar t = 0; t < 4; t++) begin : g_state
        localparam logic U = (t / 2) == 1;
        localparam logic A = (t % 2) == 1;
        localparam logic [1:0] P0 = {A, 1'b0};
        localparam logic [1:0] P1 = {A, 1'b1};
        logic [MW-1:0] cand0;
        logic [MW-1:0] cand1;
        assign cand0     = sat_add(pm_in[P0], ham2(rx, branch_sym(U, P0)));
        assign cand1     = sat_add(pm_in[P1], ham2(rx, branch_sym(U, P1)));
        // strict compare: a tie keeps the lower-numbered predecessor
        assign dec[t]    = cand1 < cand0;
        assign pm_out[t] = (cand1 < cand0) ? cand1 : cand0;
    end

endmodule

// File: rtl/vit_surv_mem.sv
module vit_surv_mem #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [3:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [3:0]    rdata
);

    logic [3:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/hd_viterbi_dec.sv
module hd_viterbi_dec
    import vit_pkg::*;
#(
    parameter int MAX_SYMS = 64,
    parameter int MW       = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_valid,
    input  logic       sym_first,
    input  logic       sym_last,
    input  logic [1:0] sym_data,
    output logic       sym_ready,
    output logic       out_valid,
    output logic       out_bit,
    output logic       out_last
);

    localparam int AW = $clog2(MAX_SYMS);
    localparam int CW = AW + 1;
    localparam logic [MW-1:0] PM_INF = {2'b01, {(MW-2){1'b0}}};
    localparam logic [3:0][MW-1:0] PM_INIT = {PM_INF, PM_INF, PM_INF, {MW{1'b0}}};
    localparam logic [AW-1:0] LAST_ADDR = AW'(MAX_SYMS - 1);

    vit_state_e state_q, state_d;

    logic [3:0][MW-1:0] pm_q, pm_src, pm_acs;
    logic [3:0]         dec_w, dec_r;
    logic [AW-1:0]      nsym_q, wr_addr, tidx_q, oidx_q;
    logic [CW-1:0]      cnt_after, olen_q;
    logic [1:0]         tst_q;
    logic [MAX_SYMS-1:0] dbits_q;
    logic               accept, start, frame_end, emit_end;

    assign accept    = sym_valid && sym_ready && (sym_first || state_q == ST_RECV);
    assign start     = accept && sym_first;
    assign pm_src    = start ? PM_INIT : pm_q;
    assign wr_addr   = start ? '0 : nsym_q;
    assign cnt_after = {1'b0, wr_addr} + 1'b1;
    assign frame_end = accept && (sym_last || wr_addr == LAST_ADDR);
    assign emit_end  = {1'b0, oidx_q} == (olen_q - 1'b1);

    vit_acs #(.MW(MW)) i_acs (
        .rx     (sym_data),
        .pm_in  (pm_src),
        .pm_out (pm_acs),
        .dec    (dec_w)
    );

    vit_surv_mem #(.DEPTH(MAX_SYMS)) i_surv (
        .clk   (clk),
        .we    (accept),
        .waddr (wr_addr),
        .wdata (dec_w),
        .raddr (tidx_q),
        .rdata (dec_r)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_RECV: begin
                if (frame_end)   state_d = (cnt_after > CW'(2)) ? ST_TRACE : ST_IDLE;
                else if (accept) state_d = ST_RECV;
            end
            ST_TRACE: if (tidx_q == '0) state_d = ST_EMIT;
            ST_EMIT:  if (emit_end)     state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pm_q    <= PM_INIT;
            nsym_q  <= '0;
            tidx_q  <= '0;
            tst_q   <= 2'b00;
            oidx_q  <= '0;
            olen_q  <= '0;
            dbits_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_RECV: begin
                    if (accept) begin
                        pm_q   <= pm_acs;
                        nsym_q <= cnt_after[AW-1:0];
                    end
                    if (frame_end) begin
                        tidx_q <= wr_addr;
                        tst_q  <= 2'b00;
                        oidx_q <= '0;
                        olen_q <= cnt_after - CW'(2);
                    end
                end
                ST_TRACE: begin
                    dbits_q[tidx_q] <= tst_q[1];
                    tst_q           <= {tst_q[0], dec_r[tst_q]};
                    tidx_q          <= tidx_q - 1'b1;
                end
                ST_EMIT: oidx_q <= oidx_q + 1'b1;
                default: ;
            endcase
        end
    end

    // output logic
    always_comb begin
        sym_ready = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_RECV: sym_ready = 1'b1;
            ST_EMIT: begin
                out_valid = 1'b1;
                out_last  = emit_end;
            end
            default: ;
        endcase
    end

    assign out_bit = dbits_q[oidx_q];

endmodule

// File: rtl/vit_checker.sv
module vit_checker (
    input logic clk,
    input logic rst_n,
    input logic sym_ready,
    input logic out_valid,
    input logic out_last
);

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && sym_ready));

    assert_last_marked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_burst_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> (!out_valid && sym_ready));

    assert_burst_contiguous_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid);

    assert_trace_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sym_ready) |-> !out_valid);

endmodule

bind hd_viterbi_dec vit_checker i_vit_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_ready (sym_ready),
    .out_valid (out_valid),
    .out_last  (out_last)
);

// File: tb/test_hd_viterbi_dec.sv
`timescale 1ns/1ps
module test_hd_viterbi_dec;

    localparam int MAXS = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_valid = 1'b0, sym_first = 1'b0, sym_last = 1'b0;
    logic [1:0] sym_data = 2'b00;
    logic sym_ready, out_valid, out_bit, out_last;

    int n_tests = 0, n_fail = 0;
    int cycles = 0;
    bit rec_bits [MAXS];
    int rec_cnt = 0, last_cnt = 0, last_pos = -1;
    bit info [MAXS];
    bit [1:0] syms [MAXS];
    int ninfo = 0, nsyms = 0;

    always #4 clk = ~clk;

    hd_viterbi_dec #(.MAX_SYMS(MAXS), .MW(10)) i_hd_viterbi_dec (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_first(sym_first),
        .sym_last(sym_last), .sym_data(sym_data), .sym_ready(sym_ready),
        .out_valid(out_valid), .out_bit(out_bit), .out_last(out_last)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (rec_cnt < MAXS) rec_bits[rec_cnt] = out_bit;
            if (out_last) begin
                last_cnt++;
                last_pos = rec_cnt;
            end
            rec_cnt++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_rec();
        rec_cnt = 0; last_cnt = 0; last_pos = -1;
    endtask

    // zero-tail encoding of info[0..L-1]
    task automatic encode(input int L);
        bit q1, q2, u;
        q1 = 0; q2 = 0;
        ninfo = L; nsyms = L + 2;
        for (int i = 0; i < L + 2; i++) begin
            u = (i < L) ? info[i] : 1'b0;
            syms[i] = {u ^ q1 ^ q2, u ^ q2};
            q2 = q1; q1 = u;
        end
    endtask

    task automatic fill_pattern(input int L, input bit [31:0] pat);
        for (int i = 0; i < L; i++) info[i] = pat[i % 32];
    endtask

    task automatic send_frame(input bit set_last);
        for (int i = 0; i < nsyms; i++) begin
            @(negedge clk);
            sym_valid = 1'b1;
            sym_first = (i == 0);
            sym_last  = set_last && (i == nsyms - 1);
            sym_data  = syms[i];
        end
        @(negedge clk);
        sym_valid = 1'b0; sym_first = 1'b0; sym_last = 1'b0;
    endtask

    task automatic wait_done();
        repeat (2 * nsyms + 8) @(negedge clk);
    endtask

    task automatic check_decode(input string req);
        int bad;
        bad = 0;
        chk(req, rec_cnt, ninfo, "decoded bit count");
        for (int i = 0; i < ninfo && i < rec_cnt; i++) if (rec_bits[i] != info[i]) bad++;
        chk(req, bad, 0, "mismatching bits");
        chk("R4", last_cnt, 1, "out_last pulses");
        chk("R4", last_pos, ninfo - 1, "out_last position");
        chk("R4", int'(sym_ready), 1, "ready after burst");
    endtask

    task automatic t_reset();
        chk("R1", int'(sym_ready), 1, "sym_ready at reset");
        chk("R1", int'(out_valid), 0, "out_valid at reset");
        chk("R1", int'(out_last), 0, "out_last at reset");
    endtask

    task automatic t_example();
        info[0] = 1; info[1] = 1; info[2] = 0; info[3] = 1;
        encode(4);
        chk("R2", int'({syms[0], syms[1], syms[2], syms[3], syms[4], syms[5]}),
            int'(12'b11_01_01_00_10_11), "encoded example");
        clear_rec(); send_frame(1'b1); wait_done();
        check_decode("R2");
    endtask

    task automatic t_single_err();
        info[0] = 1; info[1] = 1; info[2] = 0; info[3] = 1;
        encode(4);
        syms[3] ^= 2'b01;
        clear_rec(); send_frame(1'b1); wait_done();
        check_decode("R3");
    endtask

    task automatic t_long_clean();
        fill_pattern(40, 32'hB5C3_9E27);
        encode(40);
        clear_rec(); send_frame(1'b1); wait_done();
        check_decode("R2");
    endtask

    task automatic t_two_err();
        fill_pattern(40, 32'h6D2A_F10B);
        encode(40);
        syms[5]  ^= 2'b10;
        syms[30] ^= 2'b01;
        clear_rec(); send_frame(1'b1); wait_done();
        check_decode("R3");
    endtask

    task automatic t_const(input bit v);
        fill_pattern(12, v ? 32'hFFFF_FFFF : 32'h0);
        encode(12);
        clear_rec(); send_frame(1'b1); wait_done();
        check_decode("R2");
    endtask

    task automatic t_idle_ignore();
        clear_rec();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            sym_valid = 1'b1; sym_first = 1'b0; sym_last = (i == 2); sym_data = 2'b11;
        end
        @(negedge clk);
        sym_valid = 1'b0; sym_last = 1'b0;
        repeat (12) @(negedge clk);
        chk("R5", rec_cnt, 0, "output after start-less symbols");
        chk("R5", int'(sym_ready), 1, "ready after start-less symbols");
        fill_pattern(8, 32'h0000_00A6);
        encode(8);
        send_frame(1'b1); wait_done();
        check_decode("R5");
    endtask

    task automatic t_busy_ignore();
        fill_pattern(20, 32'h000C_A93D);
        encode(20);
        clear_rec(); send_frame(1'b1);
        chk("R6", int'(sym_ready), 0, "ready after closing symbol");
        sym_valid = 1'b1; sym_first = 1'b1; sym_last = 1'b1; sym_data = 2'b11;
        while (!sym_ready) @(negedge clk);
        sym_valid = 1'b0; sym_first = 1'b0; sym_last = 1'b0;
        repeat (10) @(negedge clk);
        check_decode("R6");
    endtask

    task automatic t_restart();
        fill_pattern(3, 32'h7);
        encode(3);
        clear_rec(); send_frame(1'b0);
        info[0] = 1; info[1] = 1; info[2] = 0; info[3] = 1;
        encode(4);
        send_frame(1'b1); wait_done();
        check_decode("R7");
    endtask

    task automatic t_max_len();
        fill_pattern(MAXS - 2, 32'h9A3F_5C61);
        encode(MAXS - 2);
        clear_rec(); send_frame(1'b0); wait_done();
        check_decode("R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_example();
        t_single_err();
        t_long_clean();
        t_two_err();
        t_const(1'b0);
        t_const(1'b1);
        t_idle_ignore();
        t_busy_ignore();
        t_restart();
        t_max_len();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule